// File: doc/BRIEF.md
# Configuration Register Slave for a Two-Wire Serial Bus

This block is a slave on an SMBus/I2C-style two-wire bus. Through it a host reads and writes a small file of 8-bit control registers. It is meant for programming a device once, at start-up. The block samples SCL and SDA on its own system clock. It pulls SDA low through an output-enable, which models an open-drain pad. It never stretches the clock.

Bit 7 of the command byte picks the transfer type. A value of 1 gives a single-register access, and bits 6:0 of the command then give the register offset. A value of 0 gives a block access, which walks the registers upward from register 0. A block write normally carries a byte-count byte after the command. An input strap removes that byte. A block read sends a count byte first and then the register contents. The highest register is read-only and holds a fixed identification value. The rest of the registers load their power-up values from an input port when reset is asserted.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 69h: D2h in the address byte for a write and D3h for a read. Any other address gets no acknowledge, the slave drives nothing until the next START, and no register changes.
- R2: A command byte with bit 7 = 1 selects a single-register write. Bits 6:0 give the offset. The data byte that follows is acknowledged and stored in that register.
- R3: A single-register read is an address write, a command with bit 7 = 1, a repeated START and an address read. The slave then returns the addressed register, most significant bit first.
- R4: A command byte with bit 7 = 0 selects a block write. A count byte follows, and its value is acknowledged and ignored. The data bytes then go to registers 0, 1, 2 and so on. A STOP after any whole byte ends the write, and the bytes already received are kept.
- R5: When `skip_count_i` is 1, a block write has no count byte, and the first byte after the command goes into register 0.
- R6: A block read sends a count byte equal to the number of registers (8) first. It then sends the registers from 0 upward. It continues while the master acknowledges, and a master NACK ends it.
- R7: Register 7 always reads 18h. A write to it is acknowledged and leaves it unchanged.
- R8: An access at or beyond offset 8 is handled as follows. A write byte gets no acknowledge and changes nothing. A read returns FFh. This holds for a single-register offset of 8 or more and for a block transfer that runs past register 7.
- R9: While `rst` is high, registers 0 to 6 load from `init_vals_i`, with register i in bits [8i+7:8i]. `regs_o` shows register i in bits [8i+7:8i], with register 7 in the top byte. The slave releases SDA.
- R10: A START or STOP seen at any point restarts the protocol. A STOP releases SDA and leaves the slave idle. The slave changes `sda_oe_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| skip_count_i | input | 1 | 1 removes the count byte from block writes |
| init_vals_i | input | 56 | Reset values of registers 0 to 6 |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| regs_o | output | 64 | Current contents of all registers |

## Verification
The bench builds the block with its default parameters: eight registers, address 69h, identification value 18h and a two-stage line synchronizer. With eight registers a 10-byte block transfer and a command offset of 9 both reach past the end of the file, so the NACK-on-write and FFh-on-read behaviour is covered. The read-only top register is also within reach of both single-register and block writes. Random single-register and block transfers, with and without the count byte, are checked against a bench model of the register file.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_ADDR,
    S_CMD,
    S_ACK_CMD,
    S_COUNT,
    S_ACK_COUNT,
    S_WDATA,
    S_ACK_WDATA,
    S_TX,
    S_MACK,
    S_HOLD
  } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int NLINE  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NLINE-1:0] raw_i,
  output logic [NLINE-1:0] lvl_o,
  output logic [NLINE-1:0] rise_o,
  output logic [NLINE-1:0] fall_o
);
  for (genvar g = 0; g < NLINE; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        pipe <= '1;
        prev <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw_i[g]};
        prev <= pipe[STAGES-1];
      end
    end

    assign lvl_o[g]  = pipe[STAGES-1];
    assign rise_o[g] = pipe[STAGES-1] & ~prev;
    assign fall_o[g] = ~pipe[STAGES-1] & prev;
  end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int          NREG    = 8,
  parameter logic [7:0]  ID_CODE = 8'h18,
  localparam int         AW      = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(NREG-1)*8-1:0] init_vals,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic [NREG*8-1:0]     regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == NREG - 1) begin : g_ro
      assign regs_flat[g*8 +: 8] = ID_CODE;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= init_vals[g*8 +: 8];
        else if (wr_en && wr_addr == AW'(g))
          q <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = q;
    end
  end

  assign rd_data = regs_flat[{rd_addr, 3'b000} +: 8];
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 8,
  localparam int        AW       = $clog2(NREG),
  localparam int        PW       = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_lvl,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          skip_count,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam logic [PW-1:0] PTR_END  = PW'(NREG);
  localparam logic [7:0]    CNT_BYTE = 8'(NREG);

  smb_state_e    state;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic [7:0]    tx;
  logic          rw;
  logic          byte_mode;
  logic          cnt_pend;
  logic          m_ack;
  logic [PW-1:0] ptr;
  logic [7:0]    txbyte;
  logic [PW-1:0] cmd_ptr;

  assign rd_addr = ptr[AW-1:0];
  assign txbyte  = cnt_pend ? CNT_BYTE : ((ptr < PTR_END) ? rd_data : 8'hFF);
  assign cmd_ptr = (shreg[6:0] >= 7'(NREG)) ? PTR_END : shreg[PW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      byte_mode <= 1'b0;
      cnt_pend  <= 1'b0;
      m_ack     <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state  <= S_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        if (scl_rise && (state == S_ADDR || state == S_CMD ||
                         state == S_COUNT || state == S_WDATA)) begin
          shreg  <= {shreg[6:0], sda_lvl};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_rise && state == S_TX)
          bitcnt <= bitcnt + 4'd1;
        if (scl_rise && state == S_MACK)
          m_ack <= ~sda_lvl;

        if (scl_fall) begin
          case (state)
            S_ADDR: if (bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                state  <= S_ACK_ADDR;
                sda_oe <= 1'b1;
                rw     <= shreg[0];
              end else begin
                state <= S_IDLE;
              end
            end
            S_CMD: if (bitcnt == 4'd8) begin
              state     <= S_ACK_CMD;
              sda_oe    <= 1'b1;
              byte_mode <= shreg[7];
              cnt_pend  <= ~shreg[7];
              ptr       <= shreg[7] ? cmd_ptr : '0;
            end
            S_COUNT: if (bitcnt == 4'd8) begin
              state  <= S_ACK_COUNT;
              sda_oe <= 1'b1;
            end
            S_WDATA: if (bitcnt == 4'd8) begin
              if (ptr < PTR_END) begin
                state   <= S_ACK_WDATA;
                sda_oe  <= 1'b1;
                wr_en   <= 1'b1;
                wr_addr <= ptr[AW-1:0];
                wr_data <= shreg;
                ptr     <= ptr + 1'b1;
              end else begin
                state <= S_HOLD;
              end
            end
            S_ACK_ADDR: begin
              bitcnt <= '0;
              if (rw) begin
                state  <= S_TX;
                tx     <= txbyte;
                sda_oe <= ~txbyte[7];
              end else begin
                state  <= S_CMD;
                sda_oe <= 1'b0;
              end
            end
            S_ACK_CMD: begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= (byte_mode || skip_count) ? S_WDATA : S_COUNT;
            end
            S_ACK_COUNT, S_ACK_WDATA: begin
              bitcnt <= '0;
              sda_oe <= 1'b0;
              state  <= S_WDATA;
            end
            S_TX: begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= S_MACK;
                if (cnt_pend)
                  cnt_pend <= 1'b0;
                else if (ptr < PTR_END)
                  ptr <= ptr + 1'b1;
              end else begin
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
            S_MACK: begin
              if (m_ack) begin
                bitcnt <= '0;
                state  <= S_TX;
                tx     <= txbyte;
                sda_oe <= ~txbyte[7];
              end else begin
                state <= S_HOLD;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R10: the pulled-down data line only moves while SCL is low
  p_sda_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && !start_ev && !stop_ev) |=> $stable(sda_oe));

  // R10: a STOP leaves the slave idle with SDA released
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (state == S_IDLE && !sda_oe));

  // R1: SDA is pulled only in acknowledge or transmit phases
  p_oe_phase_r1: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == S_ACK_ADDR || state == S_ACK_CMD ||
                state == S_ACK_COUNT || state == S_ACK_WDATA || state == S_TX));

  // R2: a register write follows a received data byte
  p_wr_after_data_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(state) == S_WDATA);

  // R10: a START (without STOP) begins address reception
  p_start_addr_r10: assert property (@(posedge clk) disable iff (rst)
    (start_ev && !stop_ev) |=> state == S_ADDR);
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NREG        = 8,
  parameter logic [7:0] ID_CODE     = 8'h18,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  skip_count_i,
  input  logic [(NREG-1)*8-1:0] init_vals_i,
  output logic                  sda_oe_o,
  output logic [NREG*8-1:0]     regs_o
);
  logic [1:0]    lvl, rise, fall;
  logic          start_ev, stop_ev;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          wr_en;

  smb_line_sync #(.NLINE(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign start_ev = lvl[0] & fall[1];
  assign stop_ev  = lvl[0] & rise[1];

  smb_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .scl_lvl    (lvl[0]),
    .scl_rise   (rise[0]),
    .scl_fall   (fall[0]),
    .sda_lvl    (lvl[1]),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .skip_count (skip_count_i),
    .rd_data    (rd_data),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sda_oe     (sda_oe_o)
  );

  smb_reg_bank #(.NREG(NREG), .ID_CODE(ID_CODE)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .init_vals (init_vals_i),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );
endmodule

// File: tb/smb_cfg_slave_test.sv
module smb_cfg_slave_test;
  localparam int Q = 4;
  localparam logic [55:0] INIT = 56'h3C_A5_5A_00_F0_0F_81;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        skip = 1'b0;
  logic        sda_oe;
  logic [63:0] regs;
  wire         sda_line = sda_m & ~sda_oe;

  logic [7:0] model [0:6];
  int checks = 0;
  int errs = 0;

  smb_cfg_slave uut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_m),
    .sda_i        (sda_line),
    .skip_count_i (skip),
    .init_vals_i  (INIT),
    .sda_oe_o     (sda_oe),
    .regs_o       (regs)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expv(input int i);
    if (i < 7) return model[i];
    if (i == 7) return 8'h18;
    return 8'hFF;
  endfunction

  function automatic logic [63:0] exp_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[i*8 +: 8] = expv(i);
    return f;
  endfunction

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw();
    sda_m = 1'b1; qw(); qw();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit mack);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  task automatic byte_write(input int off, input logic [7:0] data);
    bit a0, a1, a2;
    bus_start();
    wbyte(8'hD2, a0); wbyte({1'b1, 7'(off)}, a1); wbyte(data, a2);
    bus_stop();
    chk(a0 && a1, "R2 address/command ack", {62'd0, a0, a1}, 64'd3);
    chk(a2 == (off < 8), (off < 8) ? "R2 data ack" : "R8 data nack past end",
        {63'd0, a2}, {63'd0, (off < 8)});
    if (off < 7) model[off] = data;
    chk(regs == exp_flat(), (off == 7) ? "R7 read-only register kept" : "R2 register file", regs, exp_flat());
  endtask

  task automatic byte_read(input int off);
    bit a0, a1, a2;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD2, a0); wbyte({1'b1, 7'(off)}, a1);
    bus_start();
    wbyte(8'hD3, a2); rbyte(d, 1'b0);
    bus_stop();
    chk(a0 && a1 && a2, "R3 acks", {61'd0, a0, a1, a2}, 64'd7);
    chk(d == expv(off), (off < 8) ? "R3 byte read value" : "R8 read past end", {56'd0, d}, {56'd0, expv(off)});
  endtask

  task automatic block_write(input int n, input bit skp);
    bit a, ok;
    skip = skp;
    bus_start();
    wbyte(8'hD2, a); ok = a;
    wbyte(8'h00, a); ok = ok && a;
    if (!skp) begin wbyte(8'(n), a); ok = ok && a; end
    chk(ok, skp ? "R5 header acks" : "R4 header acks", {63'd0, ok}, 64'd1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wbyte(d, a);
      chk(a == (i < 8), (i < 8) ? "R4 block data ack" : "R8 block write nack past end",
          {63'd0, a}, {63'd0, (i < 8)});
      if (i < 7) model[i] = d;
      if (i >= 8) break;
    end
    bus_stop();
    chk(regs == exp_flat(), skp ? "R5 block write without count" : "R4 block write contents", regs, exp_flat());
    skip = 1'b0;
  endtask

  task automatic block_read(input int n);
    bit a0, a1, a2;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD2, a0); wbyte(8'h00, a1);
    bus_start();
    wbyte(8'hD3, a2);
    chk(a0 && a1 && a2, "R6 acks", {61'd0, a0, a1, a2}, 64'd7);
    rbyte(d, n > 0);
    chk(d == 8'd8, "R6 count byte", {56'd0, d}, 64'd8);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      chk(d == expv(i), (i < 8) ? "R6 block read data" : "R8 block read FFh", {56'd0, d}, {56'd0, expv(i)});
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 7; i++) model[i] = INIT[i*8 +: 8];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(regs == exp_flat(), "R9 reset values", regs, exp_flat());
    chk(sda_oe == 1'b0, "R9 SDA released after reset", {63'd0, sda_oe}, 64'd0);

    // R1: foreign address is ignored
    bus_start();
    wbyte(8'hA0, a);
    chk(!a, "R1 foreign address nack", {63'd0, a}, 64'd0);
    wbyte(8'h81, a);
    wbyte(8'h00, a);
    bus_stop();
    chk(regs == exp_flat(), "R1 no change after foreign address", regs, exp_flat());

    byte_write(3, 8'hC7);
    byte_read(3);
    byte_write(7, 8'h00);   // R7
    byte_read(7);           // R7
    byte_write(9, 8'h55);   // R8
    byte_read(12);          // R8
    block_write(10, 1'b0);  // R4, R8
    block_read(10);         // R6, R8
    block_write(3, 1'b1);   // R5
    block_read(4);

    // R10: aborted transfers restart the protocol
    bus_start();
    wbyte(8'hD2, a);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    bus_stop();
    chk(sda_oe == 1'b0, "R10 SDA released after STOP", {63'd0, sda_oe}, 64'd0);
    bus_start();
    wbyte(8'hD2, a);
    wbit(1'b0); wbit(1'b1);
    bus_start();
    wbyte(8'hD3, a);
    chk(a, "R10 repeated START mid-byte restarts", {63'd0, a}, 64'd1);
    rbyte(d, 1'b0);
    bus_stop();
    chk(regs == exp_flat(), "R10 no write from aborted frames", regs, exp_flat());
    byte_write(1, 8'h3E);
    byte_read(1);

    for (int t = 0; t < 30; t++) begin
      int kind, off;
      kind = int'($urandom % 5);
      off  = int'($urandom % 10);
      case (kind)
        0: byte_write(off, 8'($urandom));
        1: byte_read(off);
        2: block_write(1 + int'($urandom % 9), 1'($urandom));
        3: block_read(int'($urandom % 10));
        default: byte_read(off % 8);
      endcase
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule